// File: doc/BRIEF.md
# Transfer Descriptor Read-Skip Controller

A small data-transfer engine fetches a transfer descriptor from memory each time it is activated. This block decides, for each activation request, whether that fetch is needed or whether the descriptor kept from the last transfer can be used again. Reuse is allowed only when three things hold: the activation vector equals the vector of the last completed transfer, the skip-enable bit in the control register is set, and the last transfer did not end in a way that forces a fresh read. Three conditions force a fresh read: the last transfer was chained, a normal-mode transfer ran its count down to zero, or a block-mode transfer ran its block count down to zero.

The block also holds the 16-bit block counter used in block mode. A loaded value of zero stands for 65536 blocks. The counter steps down by one at the final element of each block, and a zero flag is raised when it steps from 1 to 0. The engine reports each finished transfer through a completion strobe, which carries the transfer's mode, its chain flag and its normal-count-zero status. The answer to each request is registered and appears one clock after the request strobe.

Top module: `dxfer_skip_ctl`

## Requirements
- R1: The control register reads 0x08 after reset. Bit 4 is the skip-enable bit: it is written by `ctl_wr` and resets to 0. Bit 3 always reads 1, and every other bit always reads 0, whatever is written.
- R2: The first request after reset asks for a fetch (`fetch_need`=1), even when skip is enabled and the vector is 0.
- R3: `fetch_valid` is high exactly in the cycle after a cycle with `req_valid` high. With skip enabled, a matching vector and no override pending, `fetch_need` is 0 in that cycle.
- R4: When skip-enable (bit 4) is 0, every request asks for a fetch.
- R5: A request whose vector differs from the vector of the last completed transfer asks for a fetch.
- R6: When the last completed transfer had its chain flag set, the next request asks for a fetch.
- R7: When the last completed transfer was in normal mode (`cur_mode`=0) with `norm_cnt_zero`=1, the next request asks for a fetch. The same status in repeat mode (`cur_mode`=1) forces nothing.
- R8: When the block counter is at zero as a block-mode transfer (`cur_mode`=2) completes, the next request asks for a fetch.
- R9: `blk_load` in block mode loads the counter. `blk_remain` then shows 1 for 0x0001, 65535 for 0xFFFF and 65536 for 0x0000.
- R10: In block mode, each cycle with `elem_last` high lowers `blk_remain` by exactly one. No other event lowers it.
- R11: In normal and repeat modes, `blk_load` and `elem_last` are ignored and `blk_remain` stays unchanged.
- R12: `blk_zero` rises when a decrement takes the count from 1 to 0. `blk_remain` then reads 0, further `elem_last` strobes leave it at 0, and a load clears the flag. After reset, `blk_zero` is 1 and `blk_remain` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| req_valid | input | 1 | Activation request strobe |
| req_vec | input | 8 | Activation vector number |
| fetch_valid | output | 1 | Decision valid, one cycle after request |
| fetch_need | output | 1 | 1: descriptor must be fetched |
| cur_mode | input | 2 | Current transfer mode: 0 normal, 1 repeat, 2 block |
| cur_chain | input | 1 | Current transfer is chained |
| norm_cnt_zero | input | 1 | Normal transfer count reached zero in this transfer |
| xfer_done | input | 1 | Transfer completion strobe |
| blk_load | input | 1 | Load block counter |
| blk_load_val | input | 16 | Block count to load |
| elem_last | input | 1 | Last element of a block transferred |
| blk_remain | output | 17 | Remaining block count (65536 shown as 0x10000) |
| blk_zero | output | 1 | Block counter has reached zero |

## Verification
The hardest case to reach from the ports is a request that is actually allowed to skip. Getting there takes a control write, a request, a completion carrying the right mode, chain and count status, and then a second request with the same vector. In block mode, it also takes a counter load and an element strobe just before the completion. The bench sweeps every combination of skip enable, chain flag, mode, end-of-count status and vector match through that full sequence. It also runs the counter from a loaded zero through all 65536 decrements, to cover the 65536-to-zero end of the range.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_REPEAT = 2'd1,
      MODE_BLOCK  = 2'd2
   } xfer_mode_e;
endpackage

// File: rtl/dxs_ctl_reg.sv
module dxs_ctl_reg #(
   parameter int REG_W   = 8,
   parameter int SKIP_BIT = 4,
   parameter int ONE_BIT  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             skip_en
);
   logic skip_q;
   logic unused_wbits;

   if (SKIP_BIT == ONE_BIT || SKIP_BIT >= REG_W || ONE_BIT >= REG_W) begin : g_bad_layout
      $error("dxs_ctl_reg: bit positions collide or exceed register width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  skip_q <= 1'b0;
      else if (wr) skip_q <= wdata[SKIP_BIT];
   end

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (b == SKIP_BIT) begin : g_rw
         assign rdata[b] = skip_q;
      end else if (b == ONE_BIT) begin : g_one
         assign rdata[b] = 1'b1;
      end else begin : g_zero
         assign rdata[b] = 1'b0;
      end
   end

   assign unused_wbits = ^wdata;
   assign skip_en = skip_q;
endmodule

// File: rtl/dxs_blk_cnt.sv
module dxs_blk_cnt #(
   parameter int CNT_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic           dec_en,
   output logic [CNT_W:0] remain,
   output logic           zero_q,
   output logic           zero_nxt
);
   localparam logic [CNT_W:0] FULL_RANGE = {1'b1, {CNT_W{1'b0}}};
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2) begin : g_bad_width
      $error("dxs_blk_cnt: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] raw_q, raw_d;
   logic             zero_d;

   always_comb begin
      raw_d  = raw_q;
      zero_d = zero_q;
      if (load_en) begin
         raw_d  = load_val;
         zero_d = 1'b0;
      end else if (dec_en && !zero_q) begin
         raw_d  = raw_q - ONE;
         zero_d = (raw_q == ONE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         zero_q <= 1'b1;
      end else begin
         raw_q  <= raw_d;
         zero_q <= zero_d;
      end
   end

   assign zero_nxt = zero_d;
   assign remain   = zero_q ? '0 : ((raw_q == '0) ? FULL_RANGE : {1'b0, raw_q});
endmodule

// File: rtl/dxs_history.sv
module dxs_history
   import dxs_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vec,
   input  logic             skip_en,
   input  logic             xfer_done,
   input  logic [1:0]       cur_mode,
   input  logic             cur_chain,
   input  logic             norm_cnt_zero,
   input  logic             blk_zero_nxt,
   output logic             fetch_valid,
   output logic             fetch_need
);
   logic [VEC_W-1:0] pend_vec_q, prev_vec_q;
   logic             prev_ok_q, prev_chain_q, prev_end_q;
   logic             reuse_ok, end_now;

   always_comb begin
      reuse_ok = prev_ok_q && skip_en && (req_vec == prev_vec_q)
                 && !prev_chain_q && !prev_end_q;
      unique case (cur_mode)
         MODE_NORMAL: end_now = norm_cnt_zero;
         MODE_BLOCK:  end_now = blk_zero_nxt;
         default:     end_now = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vec_q   <= '0;
         prev_vec_q   <= '0;
         prev_ok_q    <= 1'b0;
         prev_chain_q <= 1'b0;
         prev_end_q   <= 1'b0;
         fetch_valid  <= 1'b0;
         fetch_need   <= 1'b0;
      end else begin
         fetch_valid <= req_valid;
         if (req_valid) begin
            pend_vec_q <= req_vec;
            fetch_need <= !reuse_ok;
         end
         if (xfer_done) begin
            prev_vec_q   <= pend_vec_q;
            prev_ok_q    <= 1'b1;
            prev_chain_q <= cur_chain;
            prev_end_q   <= end_now;
         end
      end
   end
endmodule

// File: rtl/dxfer_skip_ctl.sv
module dxfer_skip_ctl
   import dxs_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int CNT_W    = 16,
   parameter int REG_W    = 8,
   parameter int SKIP_BIT = 4,
   parameter int ONE_BIT  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [REG_W-1:0] ctl_wdata,
   output logic [REG_W-1:0] ctl_rdata,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vec,
   output logic             fetch_valid,
   output logic             fetch_need,
   input  logic [1:0]       cur_mode,
   input  logic             cur_chain,
   input  logic             norm_cnt_zero,
   input  logic             xfer_done,
   input  logic             blk_load,
   input  logic [CNT_W-1:0] blk_load_val,
   input  logic             elem_last,
   output logic [CNT_W:0]   blk_remain,
   output logic             blk_zero
);
   logic skip_en, in_block, blk_zero_nxt;

   assign in_block = (cur_mode == MODE_BLOCK);

   dxs_ctl_reg #(.REG_W(REG_W), .SKIP_BIT(SKIP_BIT), .ONE_BIT(ONE_BIT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
      .rdata(ctl_rdata), .skip_en(skip_en)
   );

   dxs_blk_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load_en(blk_load && in_block), .load_val(blk_load_val),
      .dec_en(elem_last && in_block),
      .remain(blk_remain), .zero_q(blk_zero), .zero_nxt(blk_zero_nxt)
   );

   dxs_history #(.VEC_W(VEC_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
      .skip_en(skip_en), .xfer_done(xfer_done), .cur_mode(cur_mode),
      .cur_chain(cur_chain), .norm_cnt_zero(norm_cnt_zero),
      .blk_zero_nxt(blk_zero_nxt),
      .fetch_valid(fetch_valid), .fetch_need(fetch_need)
   );
endmodule

// File: rtl/dxs_skip_chk.sv
module dxs_skip_chk #(
   parameter int VEC_W    = 8,
   parameter int CNT_W    = 16,
   parameter int REG_W    = 8,
   parameter int SKIP_BIT = 4,
   parameter int ONE_BIT  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] ctl_rdata,
   input logic             req_valid,
   input logic [VEC_W-1:0] req_vec,
   input logic             fetch_valid,
   input logic             fetch_need,
   input logic [1:0]       cur_mode,
   input logic             cur_chain,
   input logic             xfer_done,
   input logic             blk_load,
   input logic             elem_last,
   input logic [CNT_W:0]   blk_remain,
   input logic             blk_zero
);
   localparam logic [REG_W-1:0] FIXED_MASK = ~(REG_W'(1) << SKIP_BIT);
   localparam logic [REG_W-1:0] FIXED_VAL  = REG_W'(1) << ONE_BIT;

   logic seen_done, last_chain;
   logic unused_vec;
   assign unused_vec = ^req_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_done  <= 1'b0;
         last_chain <= 1'b0;
      end else if (xfer_done) begin
         seen_done  <= 1'b1;
         last_chain <= cur_chain;
      end
   end

   always_comb begin
      if (rst_n) begin
         p_fixed_bits_r1: assert ((ctl_rdata & FIXED_MASK) == FIXED_VAL);
      end
   end

   p_first_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !seen_done |=> fetch_need);
   p_resp_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> fetch_valid);
   p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !fetch_valid);
   p_skip_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !ctl_rdata[SKIP_BIT] |=> fetch_need);
   p_chain_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && last_chain && !xfer_done |=> fetch_need);
   p_dec_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      elem_last && !blk_load && cur_mode == 2'd2 && !blk_zero
      |=> blk_remain == $past(blk_remain) - 1'b1);
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cur_mode != 2'd2 |=> $stable(blk_remain));
   p_zero_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
      blk_zero |-> blk_remain == '0);
endmodule

bind dxfer_skip_ctl dxs_skip_chk #(
   .VEC_W(VEC_W), .CNT_W(CNT_W), .REG_W(REG_W),
   .SKIP_BIT(SKIP_BIT), .ONE_BIT(ONE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .req_valid(req_valid),
   .req_vec(req_vec), .fetch_valid(fetch_valid), .fetch_need(fetch_need),
   .cur_mode(cur_mode), .cur_chain(cur_chain), .xfer_done(xfer_done),
   .blk_load(blk_load), .elem_last(elem_last), .blk_remain(blk_remain),
   .blk_zero(blk_zero)
);

// File: tb/dxfer_skip_ctl_tb.sv
module dxfer_skip_ctl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ctl_wr = 0;
   logic [7:0]  ctl_wdata = '0, ctl_rdata;
   logic        req_valid = 0;
   logic [7:0]  req_vec = '0;
   logic        fetch_valid, fetch_need;
   logic [1:0]  cur_mode = 2'd0;
   logic        cur_chain = 0, norm_cnt_zero = 0, xfer_done = 0;
   logic        blk_load = 0, elem_last = 0;
   logic [15:0] blk_load_val = '0;
   logic [16:0] blk_remain;
   logic        blk_zero;
   int          checks = 0, errors = 0;

   dxfer_skip_ctl u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] d);
      @(negedge clk); ctl_wr = 1; ctl_wdata = d;
      @(negedge clk); ctl_wr = 0;
   endtask

   task automatic request(input logic [7:0] v);
      @(negedge clk); req_valid = 1; req_vec = v;
      @(negedge clk); req_valid = 0;
   endtask

   task automatic complete(input logic [1:0] m, input logic ch, input logic nz);
      @(negedge clk); cur_mode = m; cur_chain = ch; norm_cnt_zero = nz; xfer_done = 1;
      @(negedge clk); xfer_done = 0; cur_chain = 0; norm_cnt_zero = 0;
   endtask

   task automatic load(input logic [1:0] m, input logic [15:0] v);
      @(negedge clk); cur_mode = m; blk_load = 1; blk_load_val = v;
      @(negedge clk); blk_load = 0;
   endtask

   task automatic strobe(input logic [1:0] m);
      @(negedge clk); cur_mode = m; elem_last = 1;
      @(negedge clk); elem_last = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 reset ctl", ctl_rdata, 8'h08);
      check("R3 reset valid", fetch_valid, 0);
      check("R12 reset zero", blk_zero, 1);
      check("R12 reset remain", blk_remain, 0);

      wr_ctl(8'hFF);
      check("R1 write ones", ctl_rdata, 8'h18);
      request(8'h00);
      check("R2 first request", fetch_need, 1);
      check("R3 valid after req", fetch_valid, 1);
      @(negedge clk);
      check("R3 valid drops", fetch_valid, 0);
      wr_ctl(8'h00);
      check("R1 write zeros", ctl_rdata, 8'h08);

      // Sweep: skip x chain x mode x end-status x vector match
      for (int s = 0; s < 2; s++)
         for (int c = 0; c < 2; c++)
            for (int m = 0; m < 3; m++)
               for (int z = 0; z < 2; z++)
                  for (int mt = 0; mt < 2; mt++) begin
                     string tag;
                     logic  exp;
                     wr_ctl(s ? 8'h10 : 8'h00);
                     request(8'h21);
                     if (m == 2) begin
                        load(2'd2, z ? 16'd1 : 16'd5);
                        strobe(2'd2);
                     end
                     complete(2'(m), c[0], z[0]);
                     request(mt ? 8'h21 : 8'h22);
                     exp = !(s && mt && !c && !(z && m != 1));
                     if (!s) tag = "R4 skip off";
                     else if (!mt) tag = "R5 mismatch";
                     else if (c) tag = "R6 chain";
                     else if (z && m == 0) tag = "R7 normal end";
                     else if (z && m == 2) tag = "R8 block end";
                     else tag = "R3 reuse";
                     check(tag, fetch_need, exp);
                  end

      load(2'd2, 16'h0000);
      check("R9 load 0", blk_remain, 17'h10000);
      load(2'd2, 16'hFFFF);
      check("R9 load FFFF", blk_remain, 65535);
      load(2'd2, 16'h0001);
      check("R9 load 1", blk_remain, 1);
      load(2'd2, 16'd3);
      strobe(2'd2);
      check("R10 decrement", blk_remain, 2);
      strobe(2'd0);
      check("R11 strobe normal", blk_remain, 2);
      strobe(2'd1);
      check("R11 strobe repeat", blk_remain, 2);
      load(2'd1, 16'd9);
      check("R11 load repeat", blk_remain, 2);
      load(2'd0, 16'd9);
      check("R11 load normal", blk_remain, 2);
      strobe(2'd2);
      check("R12 not zero at 1", blk_zero, 0);
      strobe(2'd2);
      check("R12 zero flag", blk_zero, 1);
      check("R12 zero remain", blk_remain, 0);
      strobe(2'd2);
      check("R12 hold at zero", blk_remain, 0);
      load(2'd2, 16'd4);
      check("R12 load clears", blk_zero, 0);

      load(2'd2, 16'h0000);
      @(negedge clk); elem_last = 1;
      repeat (65535) @(negedge clk);
      elem_last = 0;
      check("R10 full range to 1", blk_remain, 1);
      check("R12 no early zero", blk_zero, 0);
      strobe(2'd2);
      check("R12 full range zero", blk_zero, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule